// File: doc/BRIEF.md
# Sa6 Error Indication Counters

This block watches the Sa6 spare bit carried in timeslot 0 of the non-alignment frames of an E1 CRC-4 multiframe. An existing frame aligner supplies the received timeslot-0 bits along with the bit position inside the timeslot, the frame number inside the current 8-frame submultiframe, and a flag that is high while the receiver holds multiframe synchronisation. The block gathers the four Sa6 bits of each submultiframe into a nibble. When the nibble is complete, it tests the nibble against two code sets.

Two independent saturating event counters are kept, one per code set. The first counter tracks far-end CRC error reports. The second tracks errors detected at the reference point. The code 0011 belongs to both sets, so it advances both counters in the same submultiframe.

A read strobe copies both live counters into holding registers and restarts the live counters from zero, so each read returns the number of events since the previous read. An event that lands on the same clock edge as the read is not lost: it becomes the first count of the new interval.

Top module: `sa6_err_counter`

## Requirements
- R1: After reset, both live counters and both holding registers are zero.
- R2: A Sa6 bit is captured only on a cycle with `ts0_vld` high, `bit_pos` equal to 5 (bit 6 of the timeslot, positions counted 0 to 7), and an odd `frame_num` (1, 3, 5, 7). The bit from frame 1 becomes nibble bit 3 (MSB) and the bit from frame 7 becomes nibble bit 0. Bits at any other position or in even frames have no effect.
- R3: `cnt_a` advances by one when a completed nibble equals 0001 or 0011.
- R4: `cnt_b` advances by one when a completed nibble equals 0010 or 0011, so 0011 advances both counters on the same edge.
- R5: Any other completed nibble value leaves both counters unchanged.
- R6: When `mf_sync` is low on a cycle, any partially collected nibble is discarded. A Sa6 bit presented while `mf_sync` is low is not captured, so nothing is counted for that submultiframe.
- R7: The Sa6 bits must arrive from frames 1, 3, 5 and 7 in order. A missing or out-of-order capture discards the nibble, and a capture from frame 1 always starts a new nibble.
- R8: A counter at its all-ones value (0xFFFF for the default 16-bit width) stays there instead of wrapping.
- R9: On a clock edge where `rd_stb` is high, each holding register takes the value its live counter had before the edge, and each live counter is cleared.
- R10: An increment that falls on the same edge as a read leaves the affected live counter at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts0_vld | input | 1 | A timeslot-0 bit is present this cycle |
| ts0_bit | input | 1 | Received timeslot-0 bit value |
| bit_pos | input | 3 | Position of `ts0_bit` inside timeslot 0, 0 to 7 |
| frame_num | input | 3 | Frame number inside the current submultiframe, 0 to 7 |
| mf_sync | input | 1 | Receiver is in multiframe synchronisation |
| rd_stb | input | 1 | Copy counters to holding registers and clear them |
| cnt_a | output | CNT_W | Live count of 0001/0011 submultiframes |
| cnt_b | output | CNT_W | Live count of 0010/0011 submultiframes |
| hold_a | output | CNT_W | `cnt_a` value captured at the last read |
| hold_b | output | CNT_W | `cnt_b` value captured at the last read |

## Verification
The hardest situations to reach from the ports are a read that lands on exactly the edge that captures the fourth Sa6 bit, and a counter that has reached its saturation value. For the first, the stimulus can raise the read strobe on the frame-7 Sa6 cycle of a submultiframe. For the second, a second instance with a 3-bit counter width receives the same stream, so it saturates within a few dozen submultiframes. Random nibbles are weighted toward the four low codes. They are mixed with dropped synchronisation, skipped Sa6 captures and random reads between submultiframes.

// File: rtl/sa6_err_counter.sv
module sa6_err_counter #(
  parameter int CNT_W  = 16,
  parameter int SA_POS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ts0_vld,
  input  logic             ts0_bit,
  input  logic [2:0]       bit_pos,
  input  logic [2:0]       frame_num,
  input  logic             mf_sync,
  input  logic             rd_stb,
  output logic [CNT_W-1:0] cnt_a,
  output logic [CNT_W-1:0] cnt_b,
  output logic [CNT_W-1:0] hold_a,
  output logic [CNT_W-1:0] hold_b
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [2:0] sh;
  logic [1:0] got;

  wire       cap    = ts0_vld && mf_sync && (bit_pos == 3'(SA_POS)) && frame_num[0];
  wire [1:0] slot   = frame_num[2:1];
  wire       seq_ok = cap && (slot == 2'd0 || slot == got);
  wire       last   = seq_ok && (slot == 2'd3);
  wire [3:0] nib    = {sh, ts0_bit};
  wire       hit_a  = last && (nib == 4'b0001 || nib == 4'b0011);
  wire       hit_b  = last && (nib == 4'b0010 || nib == 4'b0011);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh  <= '0;
      got <= '0;
    end else if (!mf_sync) begin
      got <= '0;
    end else if (cap) begin
      if (seq_ok) begin
        sh  <= {sh[1:0], ts0_bit};
        got <= (slot == 2'd3) ? 2'd0 : slot + 2'd1;
      end else begin
        got <= '0;
      end
    end
  end

  function automatic logic [CNT_W-1:0] next_cnt(input logic [CNT_W-1:0] c,
                                                 input logic hit, input logic rd);
    if (rd) return {{(CNT_W-1){1'b0}}, hit};
    if (hit && c != MAXV) return c + 1'b1;
    return c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_a  <= '0;
      cnt_b  <= '0;
      hold_a <= '0;
      hold_b <= '0;
    end else begin
      cnt_a <= next_cnt(cnt_a, hit_a, rd_stb);
      cnt_b <= next_cnt(cnt_b, hit_b, rd_stb);
      if (rd_stb) begin
        hold_a <= cnt_a;
        hold_b <= cnt_b;
      end
    end
  end

  // R8
  sat_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && cnt_a == MAXV) |=> cnt_a == MAXV);
  // R8
  sat_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && cnt_b == MAXV) |=> cnt_b == MAXV);
  // R9
  hold_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> (hold_a == $past(cnt_a) && hold_b == $past(cnt_b)));
  // R10
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> (cnt_a <= 1 && cnt_b <= 1));
  // R6
  no_sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mf_sync && !rd_stb) |=> (cnt_a == $past(cnt_a) && cnt_b == $past(cnt_b)));
  // R3
  step_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> (cnt_a == $past(cnt_a) || cnt_a == $past(cnt_a) + 1'b1));
  // R4
  step_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> (cnt_b == $past(cnt_b) || cnt_b == $past(cnt_b) + 1'b1));
  // R9
  hold_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> ($stable(hold_a) && $stable(hold_b)));
endmodule

// File: tb/sa6_err_counter_tb.sv
module sa6_err_counter_tb;
  localparam int W  = 16;
  localparam int SW = 3;
  localparam int MAXW = (1 << W) - 1;
  localparam int MAXS = (1 << SW) - 1;

  logic clk = 0;
  logic rst_n = 0;
  logic ts0_vld = 0, ts0_bit = 0, mf_sync = 0, rd_stb = 0;
  logic [2:0] bit_pos = 0, frame_num = 0;
  logic [W-1:0]  cnt_a, cnt_b, hold_a, hold_b;
  logic [SW-1:0] s_a, s_b, sh_a, sh_b;

  int checks = 0, errors = 0;
  int e1 = 0, e2 = 0, h1 = 0, h2 = 0;
  int s1 = 0, s2 = 0, g1 = 0, g2 = 0;
  bit mf_on = 1;

  always #5 clk = ~clk;

  sa6_err_counter #(.CNT_W(W)) u_dut (.clk, .rst_n, .ts0_vld, .ts0_bit, .bit_pos,
    .frame_num, .mf_sync, .rd_stb, .cnt_a, .cnt_b, .hold_a, .hold_b);
  sa6_err_counter #(.CNT_W(SW)) u_dut_sat (.clk, .rst_n, .ts0_vld, .ts0_bit, .bit_pos,
    .frame_num, .mf_sync, .rd_stb, .cnt_a(s_a), .cnt_b(s_b), .hold_a(sh_a), .hold_b(sh_b));

  function automatic bit m1(input logic [3:0] n); return n == 4'b0001 || n == 4'b0011; endfunction
  function automatic bit m2(input logic [3:0] n); return n == 4'b0010 || n == 4'b0011; endfunction
  function automatic int bump(input int e, input bit hit, input bit rd, input int mx);
    if (rd) return hit ? 1 : 0;
    if (hit && e < mx) return e + 1;
    return e;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input bit b, input int p, input int f, input bit s, input bit r);
    ts0_vld = v; ts0_bit = b; bit_pos = 3'(p); frame_num = 3'(f); mf_sync = s; rd_stb = r;
    @(negedge clk);
  endtask

  task automatic check_all(input string ta, input string tb2);
    chk(ta, int'(cnt_a), e1);  chk(tb2, int'(cnt_b), e2);
    chk(ta, int'(s_a), s1);    chk(tb2, int'(s_b), s2);
  endtask

  task automatic send_smf(input logic [3:0] nib, input bit drop, input bit skip3, input bit rd_last);
    bit ok;
    for (int f = 0; f < 8; f++) begin
      for (int p = 0; p < 8; p++) begin
        bit sa = (p == 5) && f[0];
        bit b  = sa ? nib[3 - f/2] : 1'($urandom);
        bit v  = !(sa && skip3 && f == 3);
        cyc(v, b, p, f, mf_on && !(drop && f == 3), rd_last && f == 7 && p == 5);
      end
    end
    ok = mf_on && !drop && !skip3;
    if (rd_last) begin h1 = e1; h2 = e2; g1 = s1; g2 = s2; end
    e1 = bump(e1, ok && m1(nib), rd_last, MAXW);
    e2 = bump(e2, ok && m2(nib), rd_last, MAXW);
    s1 = bump(s1, ok && m1(nib), rd_last, MAXS);
    s2 = bump(s2, ok && m2(nib), rd_last, MAXS);
  endtask

  task automatic do_read(input string tag);
    cyc(0, 0, 0, 0, mf_on, 1);
    h1 = e1; h2 = e2; g1 = s1; g2 = s2;
    e1 = 0; e2 = 0; s1 = 0; s2 = 0;
    chk(tag, int'(hold_a), h1); chk(tag, int'(hold_b), h2);
    chk(tag, int'(sh_a), g1);   chk(tag, int'(sh_b), g2);
    chk(tag, int'(cnt_a), 0);   chk(tag, int'(cnt_b), 0);
    cyc(0, 0, 0, 0, mf_on, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1207));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1", int'(cnt_a), 0); chk("R1", int'(cnt_b), 0);
    chk("R1", int'(hold_a), 0); chk("R1", int'(hold_b), 0);

    // R3 / R4 / R5 directed codes, MSB from frame 1 (R2)
    send_smf(4'b0001, 0, 0, 0); check_all("R3", "R4");
    send_smf(4'b1000, 0, 0, 0); check_all("R2", "R2");
    send_smf(4'b0010, 0, 0, 0); check_all("R3", "R4");
    send_smf(4'b0100, 0, 0, 0); check_all("R2", "R2");
    send_smf(4'b0011, 0, 0, 0); check_all("R4", "R4");
    send_smf(4'b0000, 0, 0, 0); check_all("R5", "R5");
    send_smf(4'b1011, 0, 0, 0); check_all("R5", "R5");
    send_smf(4'b1111, 0, 0, 0); check_all("R5", "R5");

    // R6 sync gating
    mf_on = 0; send_smf(4'b0011, 0, 0, 0); check_all("R6", "R6");
    mf_on = 1; send_smf(4'b0011, 1, 0, 0); check_all("R6", "R6");
    // R7 missing capture
    send_smf(4'b0011, 0, 1, 0); check_all("R7", "R7");
    send_smf(4'b0001, 0, 0, 0); check_all("R7", "R7");

    // R9 read
    do_read("R9");
    // R10 coincident read
    send_smf(4'b0011, 0, 0, 0);
    send_smf(4'b0011, 0, 0, 1);
    chk("R10", int'(hold_a), h1); chk("R10", int'(hold_b), h2);
    chk("R10", int'(sh_a), g1);   chk("R10", int'(sh_b), g2);
    check_all("R10", "R10");

    // R8 saturation on narrow instance
    for (int i = 0; i < 10; i++) send_smf(4'b0011, 0, 0, 0);
    check_all("R8", "R8");
    chk("R8", int'(s_a), MAXS);
    do_read("R8");

    for (int i = 0; i < 300; i++) begin
      logic [3:0] nib = ($urandom % 2) ? 4'($urandom % 4) : 4'($urandom % 16);
      mf_on = ($urandom % 8) != 0;
      send_smf(nib, ($urandom % 10) == 0, ($urandom % 15) == 0, ($urandom % 6) == 0);
      check_all("R3", "R4");
      mf_on = 1;
      if ($urandom % 5 == 0) do_read("R9");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule